// File: doc/BRIEF.md
# Per-Counter AXI ID and Channel Filter

This block sits beside the memory-side AXI port of a DRAM controller and decides, once per clock, how much each of three event counters should advance. Every counter slot has its own configuration: an event code that chooses read or write traffic, an ID mask and compare value, a bit that picks the address channel or the data channel, a reserved port field, and a bit that switches from counting bursts to counting bytes. Because every slot filters on its own, three different IDs, or reads and writes, can be watched at once.

The block only observes handshakes. It never drives the bus. Its output is a registered increment per slot. The increment is zero when nothing qualified, and it appears one clock after the qualifying handshake. The counters that sum these increments, and the registers that hold the configuration, belong to the surrounding logic.

Top module: `axi_id_chan_filter`

## Requirements
- R1: While `rst_ni` is low, every slot of `inc_o` is zero. Slot k of any packed bus is bits `[k*W +: W]`.
- R2: A handshake qualifies only if `(id & mask) == (comp & mask)`. A mask bit of 1 makes that ID bit take part in the comparison; a mask bit of 0 leaves it out.
- R3: Each slot compares against its own mask and compare value, so different slots can pick out different IDs in the same cycle.
- R4: With `chan_sel` = 0 (address channel) and `byte_mode` = 0, an accepted address handshake adds 1. The increment shows on `inc_o` in the cycle after the handshake edge. Data-channel traffic adds nothing.
- R5: With `chan_sel` = 1 (data channel) and `byte_mode` = 0, an accepted data beat adds 1 when its last flag is set and 0 otherwise.
- R6: Event code 0x41 selects read traffic (AR and R). Event code 0x42 selects write traffic (AW and W, where W uses `w_id_i`). Any other code gives 0.
- R7: A non-zero 2-bit `port_sel` for a slot forces that slot's increment to 0. Only port 0 exists.
- R8: With `byte_mode` = 1 on the address channel, the increment is `(len+1) << size`.
- R9: With `byte_mode` = 1 on the data channel, every accepted beat counts, whether or not its last flag is set. A write beat adds the number of set bits in `w_strb_i`. A read beat adds `STRB_W`.
- R10: A channel qualifies only when valid and ready are both high in the same cycle. Otherwise the increment is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_CNT*8 | Event code per slot |
| id_mask_i | input | NUM_CNT*ID_W | ID mask per slot (1 = compare this bit) |
| id_comp_i | input | NUM_CNT*ID_W | ID compare value per slot |
| chan_sel_i | input | NUM_CNT | 0 = address channel, 1 = data channel |
| port_sel_i | input | NUM_CNT*2 | Reserved port field, must be 0 |
| byte_mode_i | input | NUM_CNT | 1 = count bytes, 0 = count bursts |
| ar_valid_i | input | 1 | Read address valid |
| ar_ready_i | input | 1 | Read address ready |
| ar_id_i | input | ID_W | Read address ID |
| ar_len_i | input | LEN_W | Read burst length minus one |
| ar_size_i | input | SIZE_W | Read beat size, log2 of bytes |
| aw_valid_i | input | 1 | Write address valid |
| aw_ready_i | input | 1 | Write address ready |
| aw_id_i | input | ID_W | Write address ID |
| aw_len_i | input | LEN_W | Write burst length minus one |
| aw_size_i | input | SIZE_W | Write beat size, log2 of bytes |
| r_valid_i | input | 1 | Read data valid |
| r_ready_i | input | 1 | Read data ready |
| r_id_i | input | ID_W | Read data ID |
| r_last_i | input | 1 | Last read beat of the burst |
| w_valid_i | input | 1 | Write data valid |
| w_ready_i | input | 1 | Write data ready |
| w_id_i | input | ID_W | Write data ID |
| w_last_i | input | 1 | Last write beat of the burst |
| w_strb_i | input | STRB_W | Write byte strobes |
| inc_o | output | NUM_CNT*INC_W | Registered increment per slot |

## Verification
A read handshake and a write handshake can land in the same cycle, and different slots then have to take their increments from different channels. The bench provokes this by driving AR and AW together with unlike lengths and sizes, and by driving R and W together with opposite last flags. Each slot's output is compared with the amount computed arithmetically for its own event, channel and mode only. The case where several slots watch one channel with different compare values is handled the same way: exactly one slot should register the hit.

// File: rtl/axf_pkg.sv
package axf_pkg;
  localparam logic [7:0] EVT_RD  = 8'h41;
  localparam logic [7:0] EVT_WR  = 8'h42;
  localparam logic       CH_ADDR = 1'b0;
  localparam logic       CH_DATA = 1'b1;

  typedef enum logic [1:0] {DIR_NONE, DIR_RD, DIR_WR} dir_e;

  function automatic dir_e decode_dir(input logic [7:0] evt);
    case (evt)
      EVT_RD:  return DIR_RD;
      EVT_WR:  return DIR_WR;
      default: return DIR_NONE;
    endcase
  endfunction
endpackage

// File: rtl/axf_id_match.sv
module axf_id_match #(
  parameter int ID_W = 16
) (
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] mask_i,
  input  logic [ID_W-1:0] comp_i,
  output logic            hit_o
);
  assign hit_o = ((id_i ^ comp_i) & mask_i) == '0;
endmodule

// File: rtl/axf_slice.sv
module axf_slice import axf_pkg::*; #(
  parameter int ID_W   = 16,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  parameter int STRB_W = 8,
  parameter int INC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        evt_i,
  input  logic [ID_W-1:0]   id_mask_i,
  input  logic [ID_W-1:0]   id_comp_i,
  input  logic              chan_sel_i,
  input  logic [1:0]        port_sel_i,
  input  logic              byte_mode_i,
  input  logic              ar_hs_i,
  input  logic [ID_W-1:0]   ar_id_i,
  input  logic [LEN_W-1:0]  ar_len_i,
  input  logic [SIZE_W-1:0] ar_size_i,
  input  logic              aw_hs_i,
  input  logic [ID_W-1:0]   aw_id_i,
  input  logic [LEN_W-1:0]  aw_len_i,
  input  logic [SIZE_W-1:0] aw_size_i,
  input  logic              r_hs_i,
  input  logic [ID_W-1:0]   r_id_i,
  input  logic              r_last_i,
  input  logic              w_hs_i,
  input  logic [ID_W-1:0]   w_id_i,
  input  logic              w_last_i,
  input  logic [STRB_W-1:0] w_strb_i,
  output logic [INC_W-1:0]  inc_o
);
  dir_e             dir;
  logic             en, hs, hit;
  logic [ID_W-1:0]  sel_id;
  logic [INC_W-1:0] amt, beats, strb_cnt;

  assign dir = decode_dir(evt_i);
  assign en  = (dir != DIR_NONE) && (port_sel_i == 2'b00);

  always_comb begin
    strb_cnt = '0;
    for (int b = 0; b < STRB_W; b++) strb_cnt = strb_cnt + INC_W'(w_strb_i[b]);
  end

  always_comb begin
    hs = 1'b0; sel_id = '0; amt = '0; beats = '0;
    if (chan_sel_i == CH_ADDR) begin
      if (dir == DIR_RD) begin
        hs = ar_hs_i; sel_id = ar_id_i;
        beats = INC_W'(ar_len_i) + INC_W'(1);
        amt = byte_mode_i ? (beats << ar_size_i) : INC_W'(1);
      end else begin
        hs = aw_hs_i; sel_id = aw_id_i;
        beats = INC_W'(aw_len_i) + INC_W'(1);
        amt = byte_mode_i ? (beats << aw_size_i) : INC_W'(1);
      end
    end else begin
      if (dir == DIR_RD) begin
        hs = r_hs_i; sel_id = r_id_i;
        amt = byte_mode_i ? INC_W'(STRB_W) : INC_W'(r_last_i);
      end else begin
        hs = w_hs_i; sel_id = w_id_i;
        amt = byte_mode_i ? strb_cnt : INC_W'(w_last_i);
      end
    end
  end

  axf_id_match #(.ID_W(ID_W)) u_match (
    .id_i(sel_id), .mask_i(id_mask_i), .comp_i(id_comp_i), .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inc_o <= '0;
    else         inc_o <= (en && hs && hit) ? amt : '0;
  end
endmodule

// File: rtl/axi_id_chan_filter.sv
module axi_id_chan_filter #(
  parameter int NUM_CNT = 3,
  parameter int ID_W    = 16,
  parameter int LEN_W   = 8,
  parameter int SIZE_W  = 3,
  parameter int STRB_W  = 8,
  localparam int INC_W  = LEN_W + 1 + (2**SIZE_W) - 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CNT*8-1:0]     evt_i,
  input  logic [NUM_CNT*ID_W-1:0]  id_mask_i,
  input  logic [NUM_CNT*ID_W-1:0]  id_comp_i,
  input  logic [NUM_CNT-1:0]       chan_sel_i,
  input  logic [NUM_CNT*2-1:0]     port_sel_i,
  input  logic [NUM_CNT-1:0]       byte_mode_i,
  input  logic                     ar_valid_i,
  input  logic                     ar_ready_i,
  input  logic [ID_W-1:0]          ar_id_i,
  input  logic [LEN_W-1:0]         ar_len_i,
  input  logic [SIZE_W-1:0]        ar_size_i,
  input  logic                     aw_valid_i,
  input  logic                     aw_ready_i,
  input  logic [ID_W-1:0]          aw_id_i,
  input  logic [LEN_W-1:0]         aw_len_i,
  input  logic [SIZE_W-1:0]        aw_size_i,
  input  logic                     r_valid_i,
  input  logic                     r_ready_i,
  input  logic [ID_W-1:0]          r_id_i,
  input  logic                     r_last_i,
  input  logic                     w_valid_i,
  input  logic                     w_ready_i,
  input  logic [ID_W-1:0]          w_id_i,
  input  logic                     w_last_i,
  input  logic [STRB_W-1:0]        w_strb_i,
  output logic [NUM_CNT*INC_W-1:0] inc_o
);
  logic ar_hs, aw_hs, r_hs, w_hs;
  assign ar_hs = ar_valid_i & ar_ready_i;
  assign aw_hs = aw_valid_i & aw_ready_i;
  assign r_hs  = r_valid_i  & r_ready_i;
  assign w_hs  = w_valid_i  & w_ready_i;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_slice
    axf_slice #(
      .ID_W(ID_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .STRB_W(STRB_W), .INC_W(INC_W)
    ) u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i[k*8 +: 8]),
      .id_mask_i  (id_mask_i[k*ID_W +: ID_W]),
      .id_comp_i  (id_comp_i[k*ID_W +: ID_W]),
      .chan_sel_i (chan_sel_i[k]),
      .port_sel_i (port_sel_i[k*2 +: 2]),
      .byte_mode_i(byte_mode_i[k]),
      .ar_hs_i    (ar_hs),
      .ar_id_i    (ar_id_i),
      .ar_len_i   (ar_len_i),
      .ar_size_i  (ar_size_i),
      .aw_hs_i    (aw_hs),
      .aw_id_i    (aw_id_i),
      .aw_len_i   (aw_len_i),
      .aw_size_i  (aw_size_i),
      .r_hs_i     (r_hs),
      .r_id_i     (r_id_i),
      .r_last_i   (r_last_i),
      .w_hs_i     (w_hs),
      .w_id_i     (w_id_i),
      .w_last_i   (w_last_i),
      .w_strb_i   (w_strb_i),
      .inc_o      (inc_o[k*INC_W +: INC_W])
    );
  end
endmodule

// File: rtl/axi_id_chan_filter_chk.sv
module axi_id_chan_filter_chk #(
  parameter int NUM_CNT = 3,
  parameter int ID_W    = 16,
  parameter int INC_W   = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_CNT*8-1:0]     evt_i,
  input logic [NUM_CNT*ID_W-1:0]  id_mask_i,
  input logic [NUM_CNT*ID_W-1:0]  id_comp_i,
  input logic [NUM_CNT-1:0]       chan_sel_i,
  input logic [NUM_CNT*2-1:0]     port_sel_i,
  input logic [NUM_CNT-1:0]       byte_mode_i,
  input logic                     ar_valid_i,
  input logic                     ar_ready_i,
  input logic [ID_W-1:0]          ar_id_i,
  input logic                     aw_valid_i,
  input logic                     aw_ready_i,
  input logic                     r_valid_i,
  input logic                     r_ready_i,
  input logic                     w_valid_i,
  input logic                     w_ready_i,
  input logic [NUM_CNT*INC_W-1:0] inc_o
);
  always_comb begin
    // R1
    if (!rst_ni) reset_zero_chk: assert (inc_o == '0);
  end

  // R10
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((ar_valid_i && ar_ready_i) || (aw_valid_i && aw_ready_i) ||
      (r_valid_i && r_ready_i) || (w_valid_i && w_ready_i)) |=> inc_o == '0);

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
    // R7
    port_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_sel_i[k*2 +: 2] != 2'b00 |=> inc_o[k*INC_W +: INC_W] == '0);
    // R6
    evt_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[k*8 +: 8] != 8'h41 && evt_i[k*8 +: 8] != 8'h42)
      |=> inc_o[k*INC_W +: INC_W] == '0);
    // R5
    burst_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chan_sel_i[k] && !byte_mode_i[k]) |=> inc_o[k*INC_W +: INC_W] <= INC_W'(1));
    // R2
    id_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[k*8 +: 8] == 8'h41 && !chan_sel_i[k] &&
       ((ar_id_i ^ id_comp_i[k*ID_W +: ID_W]) & id_mask_i[k*ID_W +: ID_W]) != '0)
      |=> inc_o[k*INC_W +: INC_W] == '0);
  end
endmodule

bind axi_id_chan_filter axi_id_chan_filter_chk #(
  .NUM_CNT(NUM_CNT), .ID_W(ID_W), .INC_W(INC_W)
) u_chk (.*);

// File: tb/axi_id_chan_filter_tb.sv
`timescale 1ns/1ps
module axi_id_chan_filter_tb;
  localparam int NC = 3, IDW = 16, LW = 8, SW = 3, SB = 8, IW = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [NC*8-1:0] evt_i;
  logic [NC*IDW-1:0] id_mask_i, id_comp_i;
  logic [NC-1:0] chan_sel_i, byte_mode_i;
  logic [NC*2-1:0] port_sel_i;
  logic ar_valid_i, ar_ready_i, aw_valid_i, aw_ready_i;
  logic r_valid_i, r_ready_i, w_valid_i, w_ready_i, r_last_i, w_last_i;
  logic [IDW-1:0] ar_id_i, aw_id_i, r_id_i, w_id_i;
  logic [LW-1:0] ar_len_i, aw_len_i;
  logic [SW-1:0] ar_size_i, aw_size_i;
  logic [SB-1:0] w_strb_i;
  logic [NC*IW-1:0] inc_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  axi_id_chan_filter #(.NUM_CNT(NC), .ID_W(IDW), .LEN_W(LW), .SIZE_W(SW), .STRB_W(SB)) u_dut (.*);

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int slot(input int k);
    return int'(inc_o[k*IW +: IW]);
  endfunction

  task automatic cfg(input int k, input logic [7:0] evt, input logic [15:0] mask,
                     input logic [15:0] comp, input logic ch, input logic [1:0] port,
                     input logic bm);
    evt_i[k*8 +: 8] = evt; id_mask_i[k*IDW +: IDW] = mask; id_comp_i[k*IDW +: IDW] = comp;
    chan_sel_i[k] = ch; port_sel_i[k*2 +: 2] = port; byte_mode_i[k] = bm;
  endtask

  task automatic idle();
    ar_valid_i = 0; ar_ready_i = 0; aw_valid_i = 0; aw_ready_i = 0;
    r_valid_i = 0; r_ready_i = 0; w_valid_i = 0; w_ready_i = 0;
    r_last_i = 0; w_last_i = 0; w_strb_i = '0;
    ar_id_i = '0; aw_id_i = '0; r_id_i = '0; w_id_i = '0;
    ar_len_i = '0; aw_len_i = '0; ar_size_i = '0; aw_size_i = '0;
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    idle();
    for (int k = 0; k < NC; k++) cfg(k, 8'h41, 16'h0, 16'h0, 1'b0, 2'b00, 1'b0);
    ar_valid_i = 1; ar_ready_i = 1;
    repeat (3) step();
    for (int k = 0; k < NC; k++) check("R1 reset", slot(k), 0);
    rst_ni = 1'b1; idle(); step();

    // R2: partial mask sweep
    cfg(0, 8'h41, 16'h00FF, 16'h3412, 1'b0, 2'b00, 1'b0);
    cfg(1, 8'h00, 16'h0, 16'h0, 1'b0, 2'b00, 1'b0);
    cfg(2, 8'h00, 16'h0, 16'h0, 1'b0, 2'b00, 1'b0);
    for (int i = 0; i < 512; i++) begin
      ar_valid_i = 1; ar_ready_i = 1; ar_id_i = 16'(i * 97);
      step();
      check("R2 mask sweep", slot(0), (ar_id_i[7:0] == 8'h12) ? 1 : 0);
    end
    // R2: full mask, single-bit flips
    cfg(0, 8'h41, 16'hFFFF, 16'hBEEF, 1'b0, 2'b00, 1'b0);
    for (int b = 0; b <= 16; b++) begin
      ar_id_i = (b == 16) ? 16'hBEEF : (16'hBEEF ^ (16'h1 << b));
      step();
      check("R2 full mask", slot(0), (b == 16) ? 1 : 0);
    end

    // R3: independent compare per slot
    for (int k = 0; k < NC; k++) cfg(k, 8'h41, 16'hFFFF, 16'(k + 1), 1'b0, 2'b00, 1'b0);
    for (int v = 1; v <= 3; v++) begin
      ar_id_i = 16'(v);
      step();
      for (int k = 0; k < NC; k++) check("R3 per-slot id", slot(k), (k + 1 == v) ? 1 : 0);
    end

    // R4/R8: AR and AW in the same cycle
    cfg(0, 8'h41, 16'h0, 16'h0, 1'b0, 2'b00, 1'b1);
    cfg(1, 8'h42, 16'h0, 16'h0, 1'b0, 2'b00, 1'b1);
    cfg(2, 8'h41, 16'h0, 16'h0, 1'b0, 2'b00, 1'b0);
    aw_valid_i = 1; aw_ready_i = 1;
    for (int len = 0; len < 256; len++) begin
      ar_len_i = 8'(len); ar_size_i = 3'(len % 4);
      aw_len_i = 8'(255 - len); aw_size_i = 3'(3 - (len % 4));
      step();
      check("R8 read addr bytes", slot(0), (len + 1) << (len % 4));
      check("R8 write addr bytes", slot(1), (256 - len) << (3 - (len % 4)));
      check("R4 addr burst", slot(2), 1);
    end

    // R5: data channel, last beats only; address slot sees no AR
    idle();
    cfg(0, 8'h41, 16'h0, 16'h0, 1'b1, 2'b00, 1'b0);
    cfg(1, 8'h42, 16'h0, 16'h0, 1'b1, 2'b00, 1'b0);
    cfg(2, 8'h41, 16'h0, 16'h0, 1'b0, 2'b00, 1'b0);
    r_valid_i = 1; r_ready_i = 1; w_valid_i = 1; w_ready_i = 1;
    for (int i = 0; i < 8; i++) begin
      r_last_i = i[0]; w_last_i = ~i[0];
      step();
      check("R5 read last", slot(0), i % 2);
      check("R5 write last", slot(1), 1 - (i % 2));
      check("R4 no data count on addr", slot(2), 0);
    end

    // R9: byte mode on data channel
    cfg(0, 8'h42, 16'h0, 16'h0, 1'b1, 2'b00, 1'b1);
    cfg(1, 8'h41, 16'h0, 16'h0, 1'b1, 2'b00, 1'b1);
    r_last_i = 0; w_last_i = 0;
    for (int s = 0; s < 256; s++) begin
      w_strb_i = 8'(s);
      step();
      check("R9 write strobes", slot(0), $countones(8'(s)));
      check("R9 read beat", slot(1), SB);
    end

    // R6: event codes with all channels handshaking
    ar_valid_i = 1; ar_ready_i = 1; aw_valid_i = 1; aw_ready_i = 1;
    r_last_i = 1; w_last_i = 1;
    begin
      logic [7:0] codes [6] = '{8'h00, 8'h40, 8'h43, 8'hFF, 8'h41, 8'h42};
      for (int c = 0; c < 6; c++) begin
        cfg(0, codes[c], 16'h0, 16'h0, 1'b0, 2'b00, 1'b0);
        step();
        check("R6 event code", slot(0), (c >= 4) ? 1 : 0);
      end
    end

    // R7: reserved port field
    for (int p = 3; p >= 0; p--) begin
      cfg(0, 8'h41, 16'h0, 16'h0, 1'b0, 2'(p), 1'b0);
      step();
      check("R7 port select", slot(0), (p == 0) ? 1 : 0);
    end

    // R10: valid or ready alone
    idle();
    cfg(0, 8'h41, 16'h0, 16'h0, 1'b0, 2'b00, 1'b0);
    cfg(1, 8'h42, 16'h0, 16'h0, 1'b1, 2'b00, 1'b0);
    ar_valid_i = 1; w_valid_i = 1; w_last_i = 1;
    step();
    check("R10 ar valid only", slot(0), 0);
    check("R10 w valid only", slot(1), 0);
    ar_valid_i = 0; ar_ready_i = 1; w_valid_i = 0; w_ready_i = 1;
    step();
    check("R10 ar ready only", slot(0), 0);
    check("R10 w ready only", slot(1), 0);
    idle(); step();
    for (int k = 0; k < NC; k++) check("R10 idle", slot(k), 0);

    summary();
  end
endmodule